// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Port

This block is the digital side of the serial port of a sampling converter. A rising edge on the convert pin starts a conversion. The conversion is modelled as a fixed number of system clocks. At the end of the conversion, the result word on `result_i` is loaded into the output shifter. The analog part is a behavioural stub outside this block. The block samples the level on the data-in pin at each accepted convert rising edge, and that level picks one of two interface modes for the next read.

In select mode, either the convert pin or the data-in pin acts as an active-low enable for the output. The output can also show a busy-low indicator while a conversion is running. In chain mode, the output is always driven. The local result goes out first, MSB first. The bits arriving on data-in follow it, so that several converters can share one output line. The convert, serial clock and data-in pins are asynchronous. Each passes through a two-flop synchroniser, and its edges are detected in the system clock domain.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, the output enable is low and no conversion is in progress.
- R2: At an accepted convert rising edge, a data-in level of 0 selects chain mode and a level of 1 selects select mode. The mode holds until the next accepted rising edge.
- R3: A conversion ends exactly CONV_CYCLES system clocks after the clock edge that registers the synchronised convert rise. Convert rising edges that arrive during a conversion are ignored.
- R4: In select mode, the output is driven only while convert is low or data-in is low, and only while a conversion is running or result bits remain. In every other case it is high impedance.
- R5: In select mode, if the enable condition holds, the output is driven low during a conversion. If the enable condition still holds when the conversion ends, the output goes high (busy indicator). One extra serial clock falling edge is then needed before the MSB appears.
- R6: The word sent is `result_i` as captured at the end of the conversion that has just completed. It is sent unsigned, MSB first, and the MSB is valid as soon as the output is enabled.
- R7: Each synchronised serial clock falling edge moves to the next bit. In select mode, a falling edge while the output is disabled has no effect.
- R8: In select mode, the output returns to high impedance after WIDTH falling edges, or WIDTH+1 falling edges when the busy indicator is on.
- R9: In chain mode, the output is always driven, and it is low during a conversion. After the conversion, the local word comes out MSB first. The data-in bit sampled at falling edge k appears on the output after falling edge k+WIDTH-1, so an upstream word directly follows the local word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert pin (asynchronous) |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| sdi_i | input | 1 | Data-in / mode / enable pin (asynchronous) |
| result_i | input | WIDTH | Result word from the converter stub |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the tri-state driver of `sdo_o` |

## Verification
Every pin change is registered by the block on the third system clock edge after it. This is two synchroniser flops plus the edge-detect register. The bench therefore waits four clocks after each pin change before it samples, and it drives and samples on falling clock edges. The end of a conversion is checked on its exact edge: the output is still busy-low after edge 2+CONV_CYCLES and high after edge 3+CONV_CYCLES, counted from the convert rise. The serial clock is held at each level for four system clocks, so each output bit is sampled well after the shift that produced it.

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 71
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic [WIDTH-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int BW = $clog2(WIDTH + 2);

  logic [2:0] cnv_p, sck_p;
  logic [1:0] sdi_p;
  logic cnv_s, sdi_s, cnv_rise, sck_fall, sel;
  logic chain, busy, flag;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnv_p <= '0;
      sck_p <= '0;
      sdi_p <= '0;
    end else begin
      cnv_p <= {cnv_p[1:0], cnv_i};
      sck_p <= {sck_p[1:0], sck_i};
      sdi_p <= {sdi_p[0], sdi_i};
    end

  assign cnv_s    = cnv_p[1];
  assign sdi_s    = sdi_p[1];
  assign cnv_rise = cnv_p[1] & ~cnv_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign sel      = ~cnv_s | ~sdi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chain <= 1'b0;
      busy  <= 1'b0;
      flag  <= 1'b0;
      cnt   <= '0;
      left  <= '0;
      sr    <= '0;
    end else if (cnv_rise && !busy) begin
      chain <= ~sdi_s;
      busy  <= 1'b1;
      flag  <= 1'b0;
      cnt   <= CW'(CONV_CYCLES - 1);
      left  <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        sr   <= result_i;
        flag <= ~chain & sel;
        left <= (~chain & sel) ? BW'(WIDTH + 1) : BW'(WIDTH);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (sck_fall && (chain || (sel && left != '0))) begin
      if (flag) flag <= 1'b0;
      else      sr   <= {sr[WIDTH-2:0], sdi_s};
      if (left != '0) left <= left - 1'b1;
    end

  assign sdo_oe_o = chain | (sel & (busy | (left != '0)));
  assign sdo_o    = busy ? 1'b0 : (flag | sr[WIDTH-1]);
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_s,
  input logic             sdi_s,
  input logic             chain,
  input logic             busy,
  input logic             left_zero,
  input logic [WIDTH-1:0] sr,
  input logic [WIDTH-1:0] result_i,
  input logic             sdo_o,
  input logic             sdo_oe_o
);
  p_hiz_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain && cnv_s && sdi_s) |-> !sdo_oe_o);

  p_busy_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdo_oe_o) |-> !sdo_o);

  p_word_captured_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sr == $past(result_i)));

  p_no_shift_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !chain && cnv_s && sdi_s) |=> $stable(sr));

  p_done_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain && !busy && left_zero) |-> !sdo_oe_o);

  p_chain_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain |-> sdo_oe_o);
endmodule

bind sar_serial_port sar_serial_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnv_s    (cnv_s),
  .sdi_s    (sdi_s),
  .chain    (chain),
  .busy     (busy),
  .left_zero(left == '0),
  .sr       (sr),
  .result_i (result_i),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o)
);

// File: tb/test_sar_serial_port.sv
module test_sar_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int CONV       = 12;

  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [W-1:0] res = '0;
  logic sdo, oe;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_serial_port #(.WIDTH(W), .CONV_CYCLES(CONV)) i_sar_serial_port (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
    .result_i(res), .sdo_o(sdo), .sdo_oe_o(oe));

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    sck = 1'b1; nclk(4);
    sck = 1'b0; nclk(4);
  endtask

  task automatic read_sel(input int n, output logic [31:0] w);
    w = 0;
    for (int k = 0; k < n; k++) begin
      w = {w[30:0], sdo};
      pulse();
    end
  endtask

  task automatic convert_select(input logic [W-1:0] v);
    res = v; sdi = 1'b1; cnv = 1'b1;
    nclk(CONV + 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w, w1, w2;
    logic [2*W-1:0] got;
    logic [W-1:0] r, u;
    nclk(3); rst_n = 1'b1; nclk(2);
    check("R1 idle after reset", {31'd0, oe}, 32'd0);

    // R9 / R2: chain mode, local word then upstream word
    for (int i = 0; i < 16; i++) begin
      r = W'(i * 37 + 5); u = W'(i * 19 + 3);
      sdi = 1'b0; cnv = 1'b0; nclk(4);
      res = r; cnv = 1'b1; nclk(6);
      check("R9 chain busy low", {30'd0, oe, sdo}, 32'd2);
      nclk(CONV);
      got = '0;
      for (int k = 0; k < 2*W; k++) begin
        got = {got[2*W-2:0], sdo};
        sdi = (k < W) ? u[W-1-k] : 1'b0;
        nclk(2);
        pulse();
      end
      check("R9 chain stream", 32'(got), 32'({r, u}));
    end
    sdi = 1'b1; cnv = 1'b0; nclk(4);

    // R2/R4/R6/R8: exhaustive select-mode sweep
    for (int v = 0; v < (1 << W); v++) begin
      convert_select(W'(v));
      check("R2 R4 deselected hiz", {31'd0, oe}, 32'd0);
      cnv = 1'b0; nclk(4);
      check("R6 MSB on enable", {30'd0, oe, sdo}, {30'd0, 1'b1, 1'(v >> (W-1))});
      read_sel(W, w);
      check("R6 word", w, 32'(v));
      check("R8 hiz after last", {31'd0, oe}, 32'd0);
    end

    // R7: falls while disabled are ignored; data-in used as enable
    cnv = 1'b0; nclk(4);
    convert_select(8'hA5);
    pulse(); pulse(); pulse();
    sdi = 1'b0; nclk(4);
    read_sel(3, w1);
    sdi = 1'b1; nclk(4);
    check("R4 deselect mid read", {31'd0, oe}, 32'd0);
    pulse(); pulse();
    sdi = 1'b0; nclk(4);
    read_sel(W - 3, w2);
    check("R7 ignored falls", (w1 << (W-3)) | w2, 32'hA5);
    check("R8 hiz after last", {31'd0, oe}, 32'd0);
    sdi = 1'b1; nclk(4);

    // R3/R5: busy indicator, exact end of conversion, ignored re-trigger
    cnv = 1'b0; nclk(4);
    res = 8'h3C; cnv = 1'b1; nclk(3);
    cnv = 1'b0; nclk(2);
    cnv = 1'b1; nclk(2);
    cnv = 1'b0; nclk(7);
    check("R5 busy low", {30'd0, oe, sdo}, 32'd2);
    nclk(1);
    check("R3 conversion end", {30'd0, oe, sdo}, 32'd3);
    res = 8'hC3;
    read_sel(W + 1, w);
    check("R5 busy bit then word", w, 32'h13C);
    check("R8 hiz after extra bit", {31'd0, oe}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule